// File: doc/BRIEF.md
# Timer Compare Unit with Force-Compare

This block is a 16-bit up-counter with one output compare channel. A host with an 8-bit register bus controls it. The counter advances only on cycles where the timer tick input is high. On each tick the counter is compared with a 16-bit compare value. On a match the unit sets an interrupt flag and updates a waveform output pin. A 2-bit output action field selects how the pin is updated.

Two waveform modes are supported:
- Free-running mode, where the counter wraps after its maximum value.
- Clear-on-match mode, where a match returns the counter to zero.

The two remaining mode codes belong to pulse-width modes, which this block does not build. Under those codes the counter runs as in free-running mode, and the force strobe is inert.

The 16-bit counter and compare registers are reached through one shared high-byte holding register, so both bytes move together. The host can also force a compare. A force updates the pin right away, but it neither raises the flag nor clears the counter. A host write to the counter suppresses the compare on the next tick.

Top module: `tmr16_cmp_unit`

## Requirements
- R1: After reset the counter, compare value, control register, holding register, flag and waveform output are all zero.
- R2: Register offsets are as follows.
  - 0: control. Bits 1:0 hold the waveform mode and bits 3:2 hold the output action. The other bits read zero.
  - 1: force register. Bit 7 is the force strobe.
  - 2 and 3: counter low and high byte.
  - 4 and 5: compare low and high byte.
  - 6: status. Bit 0 is the flag.
  - 7: reads zero.
- R3: 16-bit byte access works as follows.
  - Reading a low byte (offset 2 or 4) returns its low 8 bits and copies the matching high 8 bits into the holding register.
  - Reading a high byte (offset 3 or 5) returns the holding register.
  - Writing a high byte stores the data in the holding register.
  - Writing a low byte loads all 16 bits, taken as {holding, data}.
- R4: Each tick that is not blocked increments the counter. In mode 00 (free-running) and in the pulse-width codes, 0xFFFF is followed by 0x0000.
- R5: A real match occurs on a tick when the counter equals the compare value and no block is pending. A real match sets the flag.
- R6: On a match, the output action sets the pin as follows: 00 holds it, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R7: In mode 01 (clear-on-match), a real match loads zero into the counter in place of the increment.
- R8: Writing 1 to bit 7 of offset 1 in mode 00 or 01 applies the current output action to the pin at that clock edge. It does not set the flag and does not change the counter.
- R9: Offset 1 always reads zero. In mode codes 10 and 11 a force strobe leaves the pin unchanged.
- R10: A write to the counter low byte arms a block. On the next tick, no match is taken. A tick in the same cycle as the counter write neither counts nor compares.
- R11: Writing 1 to status bit 0 clears the flag. If a real match occurs in the same cycle, the flag is set.
- R12: If a force strobe and a real match fall in the same cycle, the output action is applied once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, zero when rd_i is low |
| tick_i | input | 1 | Timer enable tick |
| wave_o | output | 1 | Compare waveform output |
| flag_o | output | 1 | Compare match interrupt flag |

## Verification
Two functions can fall in the same cycle, and each pair is tested.
- **Force strobe and real match.** The bench writes the force strobe in the same cycle that it raises a tick with the counter equal to the compare value. The output action is toggle, so a double application would leave the pin unchanged. The expected result is a single toggle, with the flag raised by the real match.
- **Flag clear and real match.** The bench writes the flag clear on a matching tick. The flag must end up set.
- **Counter write and tick.** The bench writes the counter on a tick cycle. That tick must be dropped, and the following tick must not match.

Every outcome is judged against a behavioural model that the bench compares on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_FORCE  = 3'd1,
    REG_CNT_LO = 3'd2,
    REG_CNT_HI = 3'd3,
    REG_CMP_LO = 3'd4,
    REG_CMP_HI = 3'd5,
    REG_STAT   = 3'd6,
    REG_NONE   = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    OUT_HOLD   = 2'b00,
    OUT_TOGGLE = 2'b01,
    OUT_CLEAR  = 2'b10,
    OUT_SET    = 2'b11
  } out_mode_e;

  typedef enum logic [1:0] {
    WM_NORMAL = 2'b00,
    WM_CTC    = 2'b01,
    WM_PWM_A  = 2'b10,
    WM_PWM_B  = 2'b11
  } wave_mode_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic [BUS_W-1:0]  rdata_o,
  output wave_mode_e        mode_o,
  output out_mode_e         com_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o,
  output logic              force_o,
  output logic              flag_clr_o
);
  reg_addr_e        sel;
  logic [BUS_W-1:0] temp_q;
  logic [CNT_W-1:0] cmp_q;
  wave_mode_e       mode_q;
  out_mode_e        com_q;

  assign sel = reg_addr_e'(addr_i);

  // writes take priority over the read-side temp latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q <= '0;
      cmp_q  <= '0;
      mode_q <= WM_NORMAL;
      com_q  <= OUT_HOLD;
    end else if (wr_i) begin
      case (sel)
        REG_CTRL: begin
          mode_q <= wave_mode_e'(wdata_i[1:0]);
          com_q  <= out_mode_e'(wdata_i[3:2]);
        end
        REG_CNT_HI, REG_CMP_HI: temp_q <= wdata_i;
        REG_CMP_LO:             cmp_q  <= {temp_q, wdata_i};
        default: ;
      endcase
    end else if (rd_i) begin
      case (sel)
        REG_CNT_LO: temp_q <= cnt_i[CNT_W-1:BUS_W];
        REG_CMP_LO: temp_q <= cmp_q[CNT_W-1:BUS_W];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel)
        REG_CTRL: begin
          rdata_o[1:0] = mode_q;
          rdata_o[3:2] = com_q;
        end
        REG_CNT_LO:             rdata_o    = cnt_i[BUS_W-1:0];
        REG_CMP_LO:             rdata_o    = cmp_q[BUS_W-1:0];
        REG_CNT_HI, REG_CMP_HI: rdata_o    = temp_q;
        REG_STAT:               rdata_o[0] = flag_i;
        default:                rdata_o    = '0;
      endcase
    end
  end

  assign cnt_wr_o    = wr_i && (sel == REG_CNT_LO);
  assign cnt_wdata_o = {temp_q, wdata_i};
  // strobe only: never stored, inert under pulse-width codes
  assign force_o     = wr_i && (sel == REG_FORCE) && wdata_i[BUS_W-1] && !mode_q[1];
  assign flag_clr_o  = wr_i && (sel == REG_STAT) && wdata_i[0];
  assign mode_o      = mode_q;
  assign com_o       = com_q;
  assign cmp_o       = cmp_q;

  AST_RD_HI_TEMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (sel == REG_CNT_HI)) |=> (!wr_i && rd_i && (sel == REG_CNT_HI)) -> (rdata_o == $past(wdata_i))) // R3
    else $error("high byte read does not return holding register");
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             blk_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             blk_q;

  // a load swallows a coincident tick and arms the one-tick block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      blk_q <= 1'b1;
    end else if (tick_i) begin
      blk_q <= 1'b0;
      cnt_q <= clr_i ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign blk_o = blk_q;

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)) && blk_q) // R10
    else $error("counter load not taken");
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q)) // R4
    else $error("counter moved without tick");
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             blk_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  out_mode_e        com_i,
  input  logic             force_i,
  input  logic             flag_clr_i,
  output logic             match_o,
  output logic             wave_o,
  output logic             flag_o
);
  logic wave_q, wave_d, flag_q, act;

  assign match_o = tick_i && !load_i && !blk_i && (cnt_i == cmp_i);
  // real match and force collapse to a single application
  assign act     = match_o || force_i;

  always_comb begin
    wave_d = wave_q;
    if (act) begin
      case (com_i)
        OUT_TOGGLE: wave_d = ~wave_q;
        OUT_CLEAR:  wave_d = 1'b0;
        OUT_SET:    wave_d = 1'b1;
        default:    wave_d = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      wave_q <= wave_d;
      if (match_o)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign wave_o = wave_q;
  assign flag_o = flag_q;

  AST_WAVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_o && !force_i) |=> $stable(wave_q)) // R6
    else $error("wave moved without match or force");
  AST_SET_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && (com_i == OUT_SET)) |=> wave_q) // R6
    else $error("set action failed");
  AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> flag_q) // R11
    else $error("match did not raise flag");
  AST_FORCE_TOGGLE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && force_i && (com_i == OUT_TOGGLE)) |=> (wave_q != $past(wave_q))) // R12
    else $error("coincident force and match toggled twice");
endmodule

// File: rtl/tmr16_cmp_unit.sv
module tmr16_cmp_unit
  import tmr_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             tick_i,
  output logic             wave_o,
  output logic             flag_o
);
  wave_mode_e       mode;
  out_mode_e        com;
  logic [CNT_W-1:0] cmp_val, cnt_q, cnt_wdata;
  logic             cnt_wr, force_stb, flag_clr, blk_q, match, ctc_clr;

  tmr_regs #(.BUS_W(BUS_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt_q),
    .flag_i     (flag_o),
    .rdata_o    (rdata_o),
    .mode_o     (mode),
    .com_o      (com),
    .cmp_o      (cmp_val),
    .cnt_wr_o   (cnt_wr),
    .cnt_wdata_o(cnt_wdata),
    .force_o    (force_stb),
    .flag_clr_o (flag_clr)
  );

  assign ctc_clr = match && (mode == WM_CTC);

  tmr_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_i    (cnt_wr),
    .load_val_i(cnt_wdata),
    .clr_i     (ctc_clr),
    .cnt_o     (cnt_q),
    .blk_o     (blk_q)
  );

  tmr_compare #(.CNT_W(CNT_W)) i_compare (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_i    (cnt_wr),
    .blk_i     (blk_q),
    .cnt_i     (cnt_q),
    .cmp_i     (cmp_val),
    .com_i     (com),
    .force_i   (force_stb),
    .flag_clr_i(flag_clr),
    .match_o   (match),
    .wave_o    (wave_o),
    .flag_o    (flag_o)
  );

  AST_FORCE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_stb && !match) |=> !$rose(flag_o)) // R8
    else $error("force raised flag");
  AST_FORCE_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_stb && tick_i && !match) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))) // R8
    else $error("force disturbed counter");
  AST_LOAD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_q && tick_i && !flag_o) |=> !flag_o) // R10
    else $error("blocked tick raised flag");
  AST_CTC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && (mode == WM_CTC)) |=> (cnt_q == '0)) // R7
    else $error("clear-on-match failed");
  AST_NORMAL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr && (mode == WM_NORMAL) && (cnt_q == '1)) |=> (cnt_q == '0)) // R4
    else $error("counter did not wrap");
  AST_FORCE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i == REG_FORCE)) |-> (rdata_o == '0)) // R9
    else $error("force register read nonzero");
endmodule

// File: tb/test_tmr16_cmp_unit.sv
module test_tmr16_cmp_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0, tick_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       wave_o, flag_o;

  int n_vec = 0, n_fail = 0;
  bit done = 0;
  string req = "R1";

  // reference state
  int m_cnt, m_cmp, m_temp, m_mode, m_com, m_wave, m_flag, m_blk;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tmr16_cmp_unit i_tmr16_cmp_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i), .wave_o(wave_o), .flag_o(flag_o)
  );

  task automatic chk(string what, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int model_rd(int a);
    case (a)
      0: return (m_com << 2) | m_mode;
      2: return m_cnt & 8'hff;
      3, 5: return m_temp;
      4: return m_cmp & 8'hff;
      6: return m_flag;
      default: return 0;
    endcase
  endfunction

  task automatic model_update(int a, bit w, bit r, int d, bit t);
    bit ld, frc, hit, clr;
    ld  = w && a == 2;
    frc = w && a == 1 && d[7] && m_mode < 2;
    hit = t && !ld && !m_blk && (m_cnt == m_cmp);
    clr = w && a == 6 && d[0];
    if (hit || frc) begin
      if (m_com == 1) m_wave = 1 - m_wave;
      else if (m_com == 2) m_wave = 0;
      else if (m_com == 3) m_wave = 1;
    end
    if (hit) m_flag = 1; else if (clr) m_flag = 0;
    if (ld) begin
      m_cnt = (m_temp << 8) | d; m_blk = 1;
    end else if (t) begin
      m_blk = 0;
      m_cnt = (hit && m_mode == 1) ? 0 : (m_cnt + 1) % 65536;
    end
    if (w) begin
      if (a == 0) begin m_mode = d & 3; m_com = (d >> 2) & 3; end
      else if (a == 3 || a == 5) m_temp = d;
      else if (a == 4) m_cmp = (m_temp << 8) | d;
    end else if (r) begin
      if (a == 2) m_temp = m_cnt >> 8;
      else if (a == 4) m_temp = m_cmp >> 8;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(int a, bit w, bit r, int d, bit t);
    addr_i = a[2:0]; wr_i = w; rd_i = r; wdata_i = d[7:0]; tick_i = t;
    #1;
    if (r) chk($sformatf("rdata@%0d", a), rdata_o, model_rd(a));
    model_update(a, w, r, d, t);
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 0; rd_i = 0; tick_i = 0;
    chk("wave", wave_o, m_wave);
    chk("flag", flag_o, m_flag);
  endtask

  task automatic wr(int a, int d); step(a, 1, 0, d, 0); endtask
  task automatic rd(int a); step(a, 0, 1, 0, 0); endtask
  task automatic tk(int n); for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1); endtask
  task automatic set16(int lo_addr, int v); wr(lo_addr + 1, v >> 8); wr(lo_addr, v & 8'hff); endtask
  task automatic rd_cnt(); rd(2); rd(3); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int lfsr;
    {m_cnt, m_cmp, m_temp, m_mode, m_com, m_wave, m_flag, m_blk} = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    req = "R1"; chk("wave", wave_o, 0); chk("flag", flag_o, 0);
    rd(0); rd_cnt(); rd(4); rd(5); rd(6);
    // R2 register offsets, R3 paired byte access
    req = "R2"; wr(0, 8'hf5); rd(0); rd(7); wr(0, 0);
    req = "R3"; set16(4, 16'h1234); rd(4); rd(5); set16(2, 16'hbeef); rd_cnt();
    wr(3, 8'h77); rd(3); rd(2); rd(3);
    // R4 count and wrap
    req = "R4"; set16(4, 16'h0100); set16(2, 16'hfffd); tk(5); rd_cnt();
    // R5/R6 real match with each action
    req = "R5"; wr(0, 8'b0100); set16(4, 16'h0005); set16(2, 0); tk(8); rd(6);
    req = "R6"; wr(0, 8'b1100); wr(6, 1); set16(2, 3); tk(4);
    wr(0, 8'b1000); set16(2, 3); tk(4); rd(6);
    // R7 clear-on-match
    req = "R7"; wr(0, 8'b0101); set16(4, 3); set16(2, 0); tk(10); rd_cnt();
    // R8 force: pin only
    req = "R8"; wr(0, 8'b1101); wr(6, 1); set16(2, 0); tk(1); wr(1, 8'h80); rd(6); rd_cnt();
    wr(0, 8'b0100); wr(1, 8'h80); wr(1, 8'h80); wr(1, 8'h7f); rd(6); rd_cnt();
    step(1, 1, 0, 8'h80, 1); rd_cnt();
    // R9 pulse-width codes ignore force, offset 1 reads zero
    req = "R9"; wr(0, 8'b0110); wr(1, 8'h80); wr(0, 8'b0111); wr(1, 8'hff); rd(1); rd(0);
    // R10 counter write blocks next tick; coincident tick dropped
    req = "R10"; wr(0, 8'b0100); wr(6, 1); set16(4, 16'h0020); set16(2, 16'h0020); tk(1); rd(6); rd_cnt();
    wr(3, 0); step(2, 1, 0, 8'h1f, 1); tk(3); rd_cnt(); rd(6);
    // R11 clear vs match
    req = "R11"; wr(6, 1); rd(6); set16(2, 16'h001f); tk(1); step(6, 1, 0, 1, 1); rd(6);
    // R12 force and real match together, toggle applied once
    req = "R12"; wr(6, 1); set16(2, 16'h001e); tk(2); step(1, 1, 0, 8'h80, 1); rd(6);
    // R6 hold action leaves pin
    req = "R6"; wr(0, 8'b0001); set16(4, 2); set16(2, 0); tk(6); wr(1, 8'h80);
    // mixed traffic
    req = "R5"; lfsr = 32'h1ace;
    wr(0, 8'b0101); set16(4, 7);
    for (int i = 0; i < 600; i++) begin
      int op;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
      op = lfsr % 9;
      case (op)
        0: step(1, 1, 0, 8'h80, lfsr[4]);
        1: begin wr(3, 0); step(2, 1, 0, (lfsr >> 3) & 8'h0f, lfsr[9]); end
        2: step(6, 1, 0, 1, lfsr[5]);
        3: wr(0, (lfsr >> 4) & 8'h0f);
        4: rd_cnt();
        5: rd(6);
        default: tk(1);
      endcase
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule